// File: doc/BRIEF.md
# Patch Image Loader with Additive Checksum Gate

This block takes a patch image delivered one byte per handshake on a valid/ready stream and opened by a single-cycle start pulse. The image starts with a fixed 64-byte header. A data area follows it, and the stream may carry filler bytes after that up to a fixed total length.

The block gathers bytes into 32-bit words, least significant byte first. It latches four header fields for readout:
- a creation-date word,
- the expected checksum,
- a target-identifier byte,
- a signature word.

Each data word goes straight to a patch-store write port as soon as it is complete, and is also added into a running 32-bit sum. After the last data byte, the block compares that sum with the checksum taken from the header. It then issues either an accept or a fault verdict, and a committed-valid flag follows the result. The target identifier is only reported. It never takes part in the verdict. Filler bytes after the data area are consumed and discarded. A start pulse arriving in the middle of an image abandons that image and begins again at byte zero.

Top module: `patchLoader`

## Requirements
- R1: The stream ready output is low out of reset. It rises the cycle after a start pulse and stays high until IMAGE_BYTES bytes have been accepted.
- R2: Bytes form little-endian 32-bit words: the first byte of each group of four is bits 7:0. Data word k (byte offsets HDR_BYTES+4k to HDR_BYTES+4k+3) is written to patch address k in the cycle its fourth byte is accepted. No write happens for header or filler bytes.
- R3: The header fields are read out as follows:
  - `hdrDate`: the word at byte offset 0.
  - `hdrChecksum`: the word at byte offset 12.
  - `hdrTarget`: the byte at offset 24.
  - `hdrMarker`: the word at offset 28. A well-formed image gives 0xAAAAAA01.
- R4: `doneStrobe` pulses for exactly one cycle, the cycle after the last data byte is accepted. When the modulo-2^32 sum of all data words equals `hdrChecksum`, `acceptStrobe` pulses with it.
- R5: On a checksum mismatch, `faultStrobe` pulses together with `doneStrobe` and `acceptStrobe` stays low. A single flipped data bit causes a fault. The same flip with a recomputed checksum is accepted.
- R6: The target-identifier byte has no effect on the verdict. Images that differ only in that byte and carry a correct checksum are all accepted.
- R7: `patchValid` is set by an accept verdict. It is cleared by a fault verdict or by a start pulse, and holds otherwise.
- R8: Filler bytes between offset HDR_BYTES+DATA_BYTES and IMAGE_BYTES are accepted (ready high) without any write or strobe. After the last one, ready drops.
- R9: A start pulse forces ready low in its own cycle, so any byte offered then is not taken. It abandons the current image, clears the running sum and the write address, and restarts header capture at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Single-cycle pulse that opens (or restarts) an image |
| inValid | input | 1 | Byte offered on inData |
| inData | input | 8 | Stream byte |
| inReady | output | 1 | Block will take the offered byte this cycle |
| ramWe | output | 1 | Patch-store write enable |
| ramAddr | output | RAM_AW | Patch-store word address |
| ramData | output | 32 | Patch-store write data |
| hdrDate | output | 32 | Captured creation-date word |
| hdrChecksum | output | 32 | Captured expected checksum |
| hdrTarget | output | 8 | Captured target-identifier byte |
| hdrMarker | output | 32 | Captured signature word |
| doneStrobe | output | 1 | Data area fully received |
| acceptStrobe | output | 1 | Checksum matched |
| faultStrobe | output | 1 | Checksum mismatched |
| patchValid | output | 1 | Last completed image was accepted |

## Verification
The bound checker watches several properties on every cycle:
- every done pulse carries exactly one verdict, and no verdict appears without done;
- the valid flag rises only alongside an accept, and is never high during a fault;
- writes occur only on an accepted handshake and land inside the patch store;
- a start pulse suppresses any verdict in the following cycle.

Some behaviour can only be shown by complete images streamed through the bench:
- arithmetic correctness of the sum, including a sweep of single-bit flips over every data word, both with and without the checksum recomputed;
- little-endian word order and the resulting write contents;
- header field positions;
- indifference to the target byte;
- draining of filler;
- recovery from an aborted image.

// File: rtl/patchLoaderPkg.sv
package patchLoaderPkg;
  // Per-cycle commands from the sequencing control to the datapath.
  typedef struct packed {
    logic clrSum;     // start of image: clear running sum and write address
    logic takeByte;   // a byte is accepted this cycle
    logic capDate;    // completed word is the date field
    logic capSum;     // completed word is the expected checksum
    logic capTarget;  // current byte is the target identifier
    logic capMarker;  // completed word is the signature
    logic dataWr;     // completed word belongs to the data area
  } loadStrobes_t;
endpackage

// File: rtl/patchLoaderCtrl.sv
module patchLoaderCtrl
  import patchLoaderPkg::*;
#(
  parameter int HDR_BYTES   = 64,
  parameter int DATA_BYTES  = 896,
  parameter int IMAGE_BYTES = 2048,
  localparam int CNT_W      = $clog2(IMAGE_BYTES)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         inValid,
  input  logic         checkOk,
  output logic         inReady,
  output loadStrobes_t strobes,
  output logic         doneStrobe,
  output logic         acceptStrobe,
  output logic         faultStrobe,
  output logic         patchValid
);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(HDR_BYTES + DATA_BYTES - 1);
  localparam logic [CNT_W-1:0] IMG_LAST   = CNT_W'(IMAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] DATE_END   = CNT_W'(3);
  localparam logic [CNT_W-1:0] SUM_END    = CNT_W'(15);
  localparam logic [CNT_W-1:0] TGT_POS    = CNT_W'(24);
  localparam logic [CNT_W-1:0] MARK_END   = CNT_W'(31);

  logic             active;
  logic [CNT_W-1:0] byteCnt;
  logic             take;
  logic             wordDone;
  logic             lastData;

  assign inReady  = active & ~startIn;
  assign take     = inValid & inReady;
  assign wordDone = take & (byteCnt[1:0] == 2'b11);
  assign lastData = wordDone & (byteCnt == DATA_LAST);

  always_comb begin
    strobes.clrSum    = startIn;
    strobes.takeByte  = take;
    strobes.capDate   = wordDone & (byteCnt == DATE_END);
    strobes.capSum    = wordDone & (byteCnt == SUM_END);
    strobes.capTarget = take & (byteCnt == TGT_POS);
    strobes.capMarker = wordDone & (byteCnt == MARK_END);
    strobes.dataWr    = wordDone & (byteCnt >= DATA_FIRST) & (byteCnt <= DATA_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      byteCnt <= '0;
    end else if (startIn) begin
      active  <= 1'b1;
      byteCnt <= '0;
    end else if (take) begin
      if (byteCnt == IMG_LAST) begin
        active  <= 1'b0;
        byteCnt <= '0;
      end else begin
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe   <= 1'b0;
      acceptStrobe <= 1'b0;
      faultStrobe  <= 1'b0;
      patchValid   <= 1'b0;
    end else begin
      doneStrobe   <= lastData;
      acceptStrobe <= lastData & checkOk;
      faultStrobe  <= lastData & ~checkOk;
      if (startIn)       patchValid <= 1'b0;
      else if (lastData) patchValid <= checkOk;
    end
  end
endmodule

// File: rtl/patchLoaderDatapath.sv
module patchLoaderDatapath
  import patchLoaderPkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  loadStrobes_t      strobes,
  output logic              checkOk,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [31:0]       ramData,
  output logic [31:0]       hdrDate,
  output logic [31:0]       hdrChecksum,
  output logic [7:0]        hdrTarget,
  output logic [31:0]       hdrMarker
);
  logic [31:0]       asmReg;
  logic [31:0]       fullWord;
  logic [31:0]       runSum;
  logic [31:0]       nextSum;
  logic [RAM_AW-1:0] dataIdx;

  // Newest byte enters at the top; after four bytes the first sits in bits 7:0.
  assign fullWord = {inData, asmReg[31:8]};
  assign nextSum  = runSum + fullWord;
  assign checkOk  = (nextSum == hdrChecksum);
  assign ramWe    = strobes.dataWr;
  assign ramAddr  = dataIdx;
  assign ramData  = fullWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmReg <= '0;
    end else if (strobes.takeByte) begin
      asmReg <= fullWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runSum  <= '0;
      dataIdx <= '0;
    end else if (strobes.clrSum) begin
      runSum  <= '0;
      dataIdx <= '0;
    end else if (strobes.dataWr) begin
      runSum  <= nextSum;
      dataIdx <= dataIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrDate     <= '0;
      hdrChecksum <= '0;
      hdrTarget   <= '0;
      hdrMarker   <= '0;
    end else begin
      if (strobes.capDate)   hdrDate     <= fullWord;
      if (strobes.capSum)    hdrChecksum <= fullWord;
      if (strobes.capTarget) hdrTarget   <= inData;
      if (strobes.capMarker) hdrMarker   <= fullWord;
    end
  end
endmodule

// File: rtl/patchLoader.sv
module patchLoader
  import patchLoaderPkg::*;
#(
  parameter int  HDR_BYTES   = 64,
  parameter int  DATA_BYTES  = 896,
  parameter int  IMAGE_BYTES = 2048,
  localparam int DATA_WORDS  = DATA_BYTES / 4,
  localparam int RAM_AW      = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [31:0]       ramData,
  output logic [31:0]       hdrDate,
  output logic [31:0]       hdrChecksum,
  output logic [7:0]        hdrTarget,
  output logic [31:0]       hdrMarker,
  output logic              doneStrobe,
  output logic              acceptStrobe,
  output logic              faultStrobe,
  output logic              patchValid
);
  loadStrobes_t strobes;
  logic         checkOk;

  patchLoaderCtrl #(
    .HDR_BYTES  (HDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .IMAGE_BYTES(IMAGE_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startIn     (startIn),
    .inValid     (inValid),
    .checkOk     (checkOk),
    .inReady     (inReady),
    .strobes     (strobes),
    .doneStrobe  (doneStrobe),
    .acceptStrobe(acceptStrobe),
    .faultStrobe (faultStrobe),
    .patchValid  (patchValid)
  );

  patchLoaderDatapath #(
    .RAM_AW(RAM_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .strobes    (strobes),
    .checkOk    (checkOk),
    .ramWe      (ramWe),
    .ramAddr    (ramAddr),
    .ramData    (ramData),
    .hdrDate    (hdrDate),
    .hdrChecksum(hdrChecksum),
    .hdrTarget  (hdrTarget),
    .hdrMarker  (hdrMarker)
  );
endmodule

// File: rtl/patchLoaderChecker.sv
module patchLoaderChecker #(
  parameter int DATA_WORDS = 224,
  parameter int RAM_AW     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              inValid,
  input logic              inReady,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              doneStrobe,
  input logic              acceptStrobe,
  input logic              faultStrobe,
  input logic              patchValid
);
  localparam logic [RAM_AW:0] ADDR_LIMIT = (RAM_AW + 1)'(DATA_WORDS);

  assert_single_verdict_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (acceptStrobe ^ faultStrobe));

  assert_no_stray_verdict_R5: assert property (@(posedge clk) disable iff (!rstN)
    !doneStrobe |-> (!acceptStrobe && !faultStrobe));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(patchValid) |-> acceptStrobe);

  assert_fault_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |-> !patchValid);

  assert_write_handshake_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (inValid && inReady));

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ({1'b0, ramAddr} < ADDR_LIMIT));

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (!doneStrobe && !patchValid && !ramWe));
endmodule

bind patchLoader patchLoaderChecker #(
  .DATA_WORDS(DATA_WORDS),
  .RAM_AW    (RAM_AW)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .startIn     (startIn),
  .inValid     (inValid),
  .inReady     (inReady),
  .ramWe       (ramWe),
  .ramAddr     (ramAddr),
  .doneStrobe  (doneStrobe),
  .acceptStrobe(acceptStrobe),
  .faultStrobe (faultStrobe),
  .patchValid  (patchValid)
);

// File: tb/patchLoader_bench.sv
`timescale 1ns/1ps
module patchLoader_bench;
  localparam int HDR  = 64;
  localparam int DATA = 32;
  localparam int IMG  = 128;
  localparam int DW   = DATA / 4;
  localparam int AW   = $clog2(DW);
  localparam int LAST = HDR + DATA - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic          inValid = 1'b0;
  logic [7:0]    inData = '0;
  logic          inReady, ramWe, doneStrobe, acceptStrobe, faultStrobe, patchValid;
  logic [AW-1:0] ramAddr;
  logic [31:0]   ramData, hdrDate, hdrChecksum, hdrMarker;
  logic [7:0]    hdrTarget;

  patchLoader #(.HDR_BYTES(HDR), .DATA_BYTES(DATA), .IMAGE_BYTES(IMG)) u_patchLoader (
    .clk(clk), .rstN(rstN), .startIn(startIn), .inValid(inValid), .inData(inData),
    .inReady(inReady), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .hdrDate(hdrDate), .hdrChecksum(hdrChecksum), .hdrTarget(hdrTarget),
    .hdrMarker(hdrMarker), .doneStrobe(doneStrobe), .acceptStrobe(acceptStrobe),
    .faultStrobe(faultStrobe), .patchValid(patchValid)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0]  img [0:IMG-1];
  logic [31:0] dw  [0:DW-1];
  logic [31:0] ramModel [0:DW-1];
  logic [31:0] expSum, expDate;
  bit          expOk;
  int writeCnt, doneCnt, acceptCnt, faultCnt;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Observe outputs 1 ns after the falling edge, when driven inputs have settled.
  always @(negedge clk) begin
    #1;
    if (ramWe) begin
      ramModel[ramAddr] = ramData;
      writeCnt++;
    end
    if (doneStrobe)   doneCnt++;
    if (acceptStrobe) acceptCnt++;
    if (faultStrobe)  faultCnt++;
  end

  task automatic buildImage(input int seed, input int flipWord, input int flipBit,
                            input bit fixSum, input logic [7:0] tgt);
    logic [31:0] good, actual;
    good = '0;
    for (int k = 0; k < DW; k++) begin
      dw[k] = (32'h9E3779B9 * 32'(k + 1)) + (32'h01000193 * 32'(seed)) ^ (32'h1 << (k % 32));
      good += dw[k];
    end
    if (flipWord >= 0) dw[flipWord] ^= (32'h1 << flipBit);
    actual = '0;
    for (int k = 0; k < DW; k++) actual += dw[k];
    expSum  = fixSum ? actual : good;
    expOk   = (actual == expSum);
    expDate = 32'h20040602 + 32'(seed);
    for (int i = 0; i < HDR; i++) img[i] = 8'(i * 13 + seed);
    for (int b = 0; b < 4; b++) begin
      img[b]      = expDate[8*b +: 8];
      img[12 + b] = expSum[8*b +: 8];
    end
    img[24] = tgt;
    img[28] = 8'h01; img[29] = 8'hAA; img[30] = 8'hAA; img[31] = 8'hAA;
    for (int k = 0; k < DW; k++)
      for (int b = 0; b < 4; b++) img[HDR + 4*k + b] = dw[k][8*b +: 8];
    for (int i = HDR + DATA; i < IMG; i++) img[i] = 8'(8'hFF ^ i);
  endtask

  task automatic startPulse(input bit offerByte);
    @(negedge clk);
    startIn = 1'b1;
    inValid = offerByte;
    inData  = 8'h5A;
    #1;
    if (offerByte) check(inReady == 1'b0, "R9 ready low on start", 32'(inReady), 32'h0);
    @(negedge clk);
    startIn = 1'b0;
    inValid = 1'b0;
    check(patchValid == 1'b0, "R7 start clears valid", 32'(patchValid), 32'h0);
    writeCnt = 0; doneCnt = 0; acceptCnt = 0; faultCnt = 0;
  endtask

  task automatic sendBytes(input int nBytes, input bit gaps);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      if (i == LAST + 1) begin
        check(doneStrobe == 1'b1, "R4 done one cycle after last data byte", 32'(doneStrobe), 32'h1);
        check(acceptStrobe == expOk && faultStrobe == !expOk, "R5 verdict at done",
              {30'h0, acceptStrobe, faultStrobe}, {30'h0, expOk, !expOk});
      end
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = img[i];
      if (i == HDR) begin
        #1;
        check(inReady == 1'b1, "R1 ready while loading", 32'(inReady), 32'h1);
      end
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runImage(input string req, input bit fullChecks, input bit gaps);
    bit ramOk;
    startPulse(1'b0);
    sendBytes(IMG, gaps);
    #2;
    check(doneCnt == 1 && acceptCnt == int'(expOk) && faultCnt == int'(!expOk), req,
          32'(acceptCnt), 32'(expOk));
    check(patchValid == expOk, "R7 valid follows verdict", 32'(patchValid), 32'(expOk));
    if (fullChecks) begin
      check(inReady == 1'b0, "R8 ready drops after filler", 32'(inReady), 32'h0);
      check(writeCnt == DW, "R8 no writes for header or filler", 32'(writeCnt), 32'(DW));
      check(hdrDate == expDate, "R3 date word", hdrDate, expDate);
      check(hdrChecksum == expSum, "R3 checksum word", hdrChecksum, expSum);
      check(hdrTarget == img[24], "R3 target byte", 32'(hdrTarget), 32'(img[24]));
      check(hdrMarker == 32'hAAAAAA01, "R3 marker word", hdrMarker, 32'hAAAAAA01);
      ramOk = 1'b1;
      for (int k = 0; k < DW; k++) if (ramModel[k] !== dw[k]) ramOk = 1'b0;
      check(ramOk, "R2 little-endian patch words", ramModel[DW-1], dw[DW-1]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0, "R1 ready low after reset", 32'(inReady), 32'h0);
    check(!doneStrobe && !acceptStrobe && !faultStrobe && !patchValid && !ramWe,
          "R7 reset state quiet", {27'h0, doneStrobe, acceptStrobe, faultStrobe, patchValid, ramWe}, 32'h0);

    // R4: clean images, with and without gaps in the stream
    for (int s = 0; s < 3; s++) begin
      buildImage(s, -1, 0, 1'b0, 8'h48);
      runImage("R4 clean image accepted", 1'b1, s[0]);
    end

    // R5: sweep single-bit flips over every data word, stale and recomputed checksum
    for (int w = 0; w < DW; w++) begin
      for (int v = 0; v < 2; v++) begin
        int fb = (v == 0) ? (w % 32) : ((w * 7 + 19) % 32);
        buildImage(w + 7, w, fb, 1'b0, 8'h48);
        runImage("R5 flipped bit faults", 1'b0, 1'b0);
        buildImage(w + 7, w, fb, 1'b1, 8'h48);
        runImage("R5 flipped bit with fixed checksum accepted", 1'b0, 1'b0);
      end
    end

    // R6: target byte does not matter
    buildImage(4, -1, 0, 1'b0, 8'h00);
    runImage("R6 target 00 accepted", 1'b1, 1'b0);
    buildImage(4, -1, 0, 1'b0, 8'hA5);
    runImage("R6 target A5 accepted", 1'b1, 1'b1);

    // R7: fault after accept clears valid
    buildImage(9, 2, 5, 1'b0, 8'h48);
    runImage("R7 fault after accept", 1'b0, 1'b0);

    // R9: abort mid-data, restart with an offered byte on the start cycle
    buildImage(11, -1, 0, 1'b0, 8'h48);
    startPulse(1'b0);
    sendBytes(HDR + 12, 1'b0);
    startPulse(1'b1);
    sendBytes(IMG, 1'b0);
    #2;
    check(acceptCnt == 1 && faultCnt == 0, "R9 restarted image accepted", 32'(acceptCnt), 32'h1);
    check(writeCnt == DW, "R9 write address restarted", 32'(writeCnt), 32'(DW));
    check(hdrChecksum == expSum, "R9 header recaptured", hdrChecksum, expSum);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule